// File: doc/BRIEF.md
# Bus-Mastering Tape DMA Engine with Chained Grant

This block moves bytes between an 8-bit tape port and a 16-bit memory bus as a bus master. The host side only arbitrates. It hands out a single acknowledge that travels down a chain of masters sharing one channel. This engine generates the memory address, the read and write strobes and the byte-lane select itself. Software loads a 23-bit word address as three byte fields, then loads a byte count. Writing the count arms the engine.

In tape-to-memory mode the engine holds one byte taken from the tape port and writes it to memory. In memory-to-tape mode it reads one byte from memory and offers it to the tape port. Successive bytes fill the even lane and then the odd lane of each word, and the word address advances after every odd-lane byte. After the last byte the engine stops requesting and raises a one-cycle pulse for the interrupt logic.

Top module: `dma_chain_master`

## Requirements
- R1: While reset is asserted, dmaReq, memRd, memWr, tapeInReady, tapeOutValid and tcPulse are low, and memAddr and memBhe are zero.
- R2: When the engine has no request of its own, ackOut equals ackIn in the same cycle.
- R3: When dmaReq and ackIn are both high, ackOut is low and the engine drives a memory strobe in that cycle.
- R4: A config write with cfgSel=0 loads word-address bits 7:0 from cfgData[7:0] and returns the lane to even. cfgSel=1 loads bits 15:8 and cfgSel=2 loads bits 22:16 from cfgData[6:0]. The new value appears on memAddr in the next cycle. The address counter wraps modulo 2^23 and carries across the field boundaries.
- R5: The first transfer after a cfgSel=0 write uses memBhe=0. memBhe toggles after each completed transfer. memAddr increments by one after each completed transfer made with memBhe=1.
- R6: Tape-to-memory mode (rdOp=1, wrOp=0): while the engine is armed and its holding byte is empty, tapeInReady is high and a byte is taken when tapeInValid is high. A held byte raises dmaReq. When the grant arrives, memWr is high and memWData carries the byte in both halves.
- R7: Memory-to-tape mode (wrOp=1, rdOp=0): while the engine is armed and its holding byte is empty, it requests. When granted it drives memRd. On completion it captures memRData[15:8] if memBhe=1, otherwise memRData[7:0]. It then holds that byte on tapeOutData with tapeOutValid high until tapeOutReady is high.
- R8: A config write with cfgSel=3 loads N from cfgData and arms the engine. Exactly N+1 transfers then complete. tcPulse is high for the single cycle after the last completion, and dmaReq stays low from that cycle until the next count load.
- R9: With neither or both of rdOp and wrOp set, there is no request, no memory strobe, no tape handshake, and ackIn passes through to ackOut.
- R10: A transfer completes only in a cycle with a strobe and memReady both high. While memReady is low, memAddr and memBhe hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Config write strobe |
| cfgSel | input | 2 | Config target: 0/1/2 address fields (low/mid/high), 3 byte count |
| cfgData | input | 16 | Config write data |
| rdOp | input | 1 | Tape-to-memory enable |
| wrOp | input | 1 | Memory-to-tape enable |
| tapeInValid | input | 1 | Tape byte offered |
| tapeInData | input | 8 | Tape byte in |
| tapeInReady | output | 1 | Engine accepts a tape byte |
| tapeOutValid | output | 1 | Byte offered to tape |
| tapeOutData | output | 8 | Byte out to tape |
| tapeOutReady | input | 1 | Tape accepts the byte |
| dmaReq | output | 1 | Channel request |
| ackIn | input | 1 | Acknowledge from upstream |
| ackOut | output | 1 | Acknowledge to downstream |
| memAddr | output | 23 | Memory word address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memBhe | output | 1 | Odd (high) byte lane select |
| memWData | output | 16 | Memory write data |
| memRData | input | 16 | Memory read data |
| memReady | input | 1 | Memory completes the access |
| tcPulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench targets the grant chain under a toggling acknowledge. If the engine let the grant through while it held a request, two masters would drive the bus together. If it swallowed the grant while idle, downstream masters would starve. Address carries are checked across field boundaries and at the 23-bit wrap: a lane or increment error there puts every later byte at the wrong address. Runs of odd length and runs stalled by memReady show whether the count ends one byte early or late, and whether tcPulse lasts more than one cycle. Setting both mode bits at once shows whether the engine still requests when it should not.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int ADDR_FIELDS = 3;

  typedef enum logic [1:0] {
    SEL_ADDR_LO  = 2'd0,
    SEL_ADDR_MID = 2'd1,
    SEL_ADDR_HI  = 2'd2,
    SEL_COUNT    = 2'd3
  } cfgSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [ADDR_FIELDS-1:0] ldAddr;
    logic ldCount;
    logic step;      // one transfer completed on the memory bus
    logic takeTape;  // capture byte from tape port
    logic takeMem;   // capture byte from memory read data
  } dmaStrobe_t;
endpackage

// File: rtl/dma_grant_link.sv
`timescale 1ns/1ps
module dma_grant_link (
  input  logic reqIn,
  input  logic ackIn,
  output logic ackOut,
  output logic grant
);
  // a pending local request consumes the acknowledge, otherwise it flows on
  assign grant  = ackIn & reqIn;
  assign ackOut = ackIn & ~reqIn;
endmodule

// File: rtl/dma_chain_ctrl.sv
`timescale 1ns/1ps
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       rdOp,
  input  logic       wrOp,
  input  logic       tapeInValid,
  input  logic       tapeOutReady,
  input  logic       grant,
  input  logic       memReady,
  input  logic       lastByte,
  output dmaStrobe_t strb,
  output logic       dmaReq,
  output logic       memRd,
  output logic       memWr,
  output logic       tapeInReady,
  output logic       tapeOutValid,
  output logic       tcPulse
);
  logic armed, holdFull;
  logic modeRd, modeWr, xferDone, takeTape, drainTape;
  cfgSel_e selE;

  assign selE   = cfgSel_e'(cfgSel);
  assign modeRd = rdOp & ~wrOp;
  assign modeWr = wrOp & ~rdOp;

  assign dmaReq       = armed & ((modeRd & holdFull) | (modeWr & ~holdFull));
  assign memWr        = grant & modeRd;
  assign memRd        = grant & modeWr;
  assign xferDone     = grant & memReady;
  assign tapeInReady  = armed & modeRd & ~holdFull;
  assign tapeOutValid = modeWr & holdFull;
  assign takeTape     = tapeInValid & tapeInReady;
  assign drainTape    = tapeOutValid & tapeOutReady;

  always_comb begin
    strb = '0;
    for (int f = 0; f < ADDR_FIELDS; f++)
      strb.ldAddr[f] = cfgWe && (cfgSel == f[1:0]);
    strb.ldCount  = cfgWe && (selE == SEL_COUNT);
    strb.step     = xferDone;
    strb.takeTape = takeTape;
    strb.takeMem  = xferDone & modeWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      holdFull <= 1'b0;
      tcPulse  <= 1'b0;
    end else begin
      if (strb.ldCount)              armed <= 1'b1;
      else if (xferDone && lastByte) armed <= 1'b0;

      if (takeTape || strb.takeMem)              holdFull <= 1'b1;
      else if ((xferDone && modeRd) || drainTape) holdFull <= 1'b0;

      tcPulse <= xferDone & lastByte;
    end
  end

  // R9: strobes and tape handshake only with exactly one mode bit set
  p_mode_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || tapeInReady) |-> (rdOp ^ wrOp));

  // R8: no request in the cycle after the final transfer
  p_req_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && lastByte && !strb.ldCount) |=> !dmaReq);

  // R8: terminal pulse lasts one cycle unless the count is reloaded
  p_tc_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse && !cfgWe && !strb.ldCount) |=> !tcPulse);
endmodule

// File: rtl/dma_chain_dp.sv
`timescale 1ns/1ps
module dma_chain_dp
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dmaStrobe_t          strb,
  input  logic [CNT_W-1:0]    cfgData,
  input  logic [BYTE_W-1:0]   tapeInData,
  input  logic [2*BYTE_W-1:0] memRData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memBhe,
  output logic [2*BYTE_W-1:0] memWData,
  output logic [BYTE_W-1:0]   tapeOutData,
  output logic                lastByte
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] wordAddr, loadedAddr;
  logic              oddLane;
  logic [CNT_W-1:0]  remain;
  logic [BYTE_W-1:0] holdByte;

  // per-field load mux; the top field takes whatever width remains
  for (genvar f = 0; f < ADDR_FIELDS; f++) begin : g_field
    localparam int LO = f * BYTE_W;
    localparam int FW = (ADDR_W - LO < BYTE_W) ? (ADDR_W - LO) : BYTE_W;
    assign loadedAddr[LO +: FW] = strb.ldAddr[f] ? cfgData[FW-1:0] : wordAddr[LO +: FW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
      oddLane  <= 1'b0;
      remain   <= '0;
      holdByte <= '0;
    end else begin
      if (|strb.ldAddr)            wordAddr <= loadedAddr;
      else if (strb.step && oddLane) wordAddr <= wordAddr + ADDR_ONE;

      if (strb.ldAddr[0])  oddLane <= 1'b0;
      else if (strb.step)  oddLane <= ~oddLane;

      if (strb.ldCount)                         remain <= cfgData;
      else if (strb.step && remain != '0)       remain <= remain - CNT_ONE;

      if (strb.takeTape)     holdByte <= tapeInData;
      else if (strb.takeMem) holdByte <= oddLane ? memRData[2*BYTE_W-1:BYTE_W]
                                                 : memRData[BYTE_W-1:0];
    end
  end

  assign memAddr     = wordAddr;
  assign memBhe      = oddLane;
  assign memWData    = {holdByte, holdByte};
  assign tapeOutData = holdByte;
  assign lastByte    = (remain == '0);

  // R5: an even-lane transfer leaves the word address where it was
  p_even_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !oddLane && !(|strb.ldAddr)) |=> $stable(memAddr));

  // R5: every completed transfer flips the lane
  p_lane_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.ldAddr[0]) |=> (memBhe != $past(memBhe)));
endmodule

// File: rtl/dma_chain_master.sv
`timescale 1ns/1ps
module dma_chain_master
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgSel,
  input  logic [CNT_W-1:0]    cfgData,
  input  logic                rdOp,
  input  logic                wrOp,
  input  logic                tapeInValid,
  input  logic [BYTE_W-1:0]   tapeInData,
  output logic                tapeInReady,
  output logic                tapeOutValid,
  output logic [BYTE_W-1:0]   tapeOutData,
  input  logic                tapeOutReady,
  output logic                dmaReq,
  input  logic                ackIn,
  output logic                ackOut,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic                memBhe,
  output logic [2*BYTE_W-1:0] memWData,
  input  logic [2*BYTE_W-1:0] memRData,
  input  logic                memReady,
  output logic                tcPulse
);
  dmaStrobe_t strb;
  logic grant, lastByte;

  dma_grant_link u_link (
    .reqIn (dmaReq),
    .ackIn (ackIn),
    .ackOut(ackOut),
    .grant (grant)
  );

  dma_chain_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgSel      (cfgSel),
    .rdOp        (rdOp),
    .wrOp        (wrOp),
    .tapeInValid (tapeInValid),
    .tapeOutReady(tapeOutReady),
    .grant       (grant),
    .memReady    (memReady),
    .lastByte    (lastByte),
    .strb        (strb),
    .dmaReq      (dmaReq),
    .memRd       (memRd),
    .memWr       (memWr),
    .tapeInReady (tapeInReady),
    .tapeOutValid(tapeOutValid),
    .tcPulse     (tcPulse)
  );

  dma_chain_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgData    (cfgData),
    .tapeInData (tapeInData),
    .memRData   (memRData),
    .memAddr    (memAddr),
    .memBhe     (memBhe),
    .memWData   (memWData),
    .tapeOutData(tapeOutData),
    .lastByte   (lastByte)
  );

  // R3: a strobe on the bus means the acknowledge stopped here
  p_grant_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (ackIn && !ackOut));

  // R6/R7: never both strobes
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R10: a stalled access keeps address and lane
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && !memReady && !cfgWe) |=> ($stable(memAddr) && $stable(memBhe)));
endmodule

// File: tb/dma_chain_master_bench.sv
`timescale 1ns/1ps
module dma_chain_master_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, cfgWe, rdOp, wrOp, tapeInValid, tapeOutReady, ackIn, memReady;
  logic [1:0]  cfgSel;
  logic [15:0] cfgData;
  logic [7:0]  tapeInData;
  logic        tapeInReady, tapeOutValid, dmaReq, ackOut, memRd, memWr, memBhe, tcPulse;
  logic [7:0]  tapeOutData;
  logic [22:0] memAddr;
  logic [15:0] memWData, memRData;

  dma_chain_master u_dma_chain_master (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .rdOp(rdOp), .wrOp(wrOp), .tapeInValid(tapeInValid), .tapeInData(tapeInData),
    .tapeInReady(tapeInReady), .tapeOutValid(tapeOutValid), .tapeOutData(tapeOutData),
    .tapeOutReady(tapeOutReady), .dmaReq(dmaReq), .ackIn(ackIn), .ackOut(ackOut),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memBhe(memBhe),
    .memWData(memWData), .memRData(memRData), .memReady(memReady), .tcPulse(tcPulse)
  );

  // memory stub: read data is a fixed function of the word address
  assign memRData = {memAddr[7:0] ^ 8'h5A, ~memAddr[7:0]};

  int nRun = 0, nFail = 0, cyc = 0, pat = 0;
  int xferCount = 0, tcCount = 0;

  // reference state
  logic [22:0] mWord;
  bit          mOdd, mArmed, mHeld, mTc;
  int          mLeft;
  logic [7:0]  mVal;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // stimulus patterns applied just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (pat)
      0: begin ackIn = cyc[0]; memReady = 1'b0; tapeInValid = 1'b0; tapeOutReady = 1'b0; end
      1: begin ackIn = 1'b1; memReady = 1'b1; tapeInValid = 1'b1; tapeOutReady = 1'b1; end
      default: begin
        ackIn        = (cyc % 5) != 0;
        memReady     = (cyc % 3) != 1;
        tapeInValid  = (cyc % 4) != 2;
        tapeOutReady = cyc[0];
      end
    endcase
    tapeInData = 8'(cyc * 7 + 3);
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  // per-cycle comparison and reference update
  always @(negedge clk) begin
    if (rstN) begin
      bit rd, wr, eReq, eGr, eTin, eTov, done;
      rd   = rdOp && !wrOp;
      wr   = wrOp && !rdOp;
      eReq = mArmed && ((rd && mHeld) || (wr && !mHeld));
      eGr  = eReq && ackIn;
      eTin = mArmed && rd && !mHeld;
      eTov = wr && mHeld;
      chk("R9 dmaReq", 32'(dmaReq), 32'(eReq));
      chk(eReq ? "R3 ackOut blocked" : "R2 ackOut passed", 32'(ackOut), 32'(ackIn && !eReq));
      chk("R6 memWr", 32'(memWr), 32'(eGr && rd));
      chk("R7 memRd", 32'(memRd), 32'(eGr && wr));
      chk("R4 memAddr", 32'(memAddr), 32'(mWord));
      chk("R5 memBhe", 32'(memBhe), 32'(mOdd));
      chk("R8 tcPulse", 32'(tcPulse), 32'(mTc));
      chk("R9 tapeInReady", 32'(tapeInReady), 32'(eTin));
      chk("R7 tapeOutValid", 32'(tapeOutValid), 32'(eTov));
      if (eTov) chk("R7 tapeOutData", 32'(tapeOutData), 32'(mVal));
      if (eGr && rd) chk("R6 memWData", 32'(memWData), 32'({mVal, mVal}));

      done = eGr && memReady;   // R10
      mTc  = 1'b0;
      if (cfgWe) begin
        case (cfgSel)
          2'd0: begin mWord[7:0] = cfgData[7:0]; mOdd = 1'b0; end
          2'd1: mWord[15:8]  = cfgData[7:0];
          2'd2: mWord[22:16] = cfgData[6:0];
          default: begin mLeft = int'(cfgData) + 1; mArmed = 1'b1; end
        endcase
      end
      if (tapeInValid && eTin) begin mHeld = 1'b1; mVal = tapeInData; end
      if (eTov && tapeOutReady) mHeld = 1'b0;
      if (done) begin
        xferCount++;
        if (rd) mHeld = 1'b0;
        else begin
          mHeld = 1'b1;
          mVal  = mOdd ? (mWord[7:0] ^ 8'h5A) : ~mWord[7:0];
        end
        if (mOdd) mWord = mWord + 23'd1;
        mOdd = !mOdd;
        mLeft--;
        if (mLeft == 0) begin mArmed = 1'b0; mTc = 1'b1; tcCount++; end
      end
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic waitTc(input int limit);
    int t0;
    t0 = tcCount;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tcCount != t0) return;
    end
    nRun++; nFail++;
    $display("FAIL R8 terminal count never reached actual=0 expected=1");
  endtask

  initial begin
    int x0, t0;
    rstN = 1'b0; cfgWe = 1'b0; cfgSel = 2'd0; cfgData = '0; rdOp = 1'b0; wrOp = 1'b0;
    ackIn = 1'b0; memReady = 1'b0; tapeInValid = 1'b0; tapeOutReady = 1'b0; tapeInData = '0;
    mWord = '0; mOdd = 0; mArmed = 0; mHeld = 0; mTc = 0; mLeft = 0; mVal = '0;
    repeat (3) @(negedge clk);
    chk("R1 dmaReq", 32'(dmaReq), 0);
    chk("R1 memRd", 32'(memRd), 0);
    chk("R1 memWr", 32'(memWr), 0);
    chk("R1 tapeInReady", 32'(tapeInReady), 0);
    chk("R1 tapeOutValid", 32'(tapeOutValid), 0);
    chk("R1 tcPulse", 32'(tcPulse), 0);
    chk("R1 memAddr", 32'(memAddr), 0);
    chk("R1 memBhe", 32'(memBhe), 0);
    @(posedge clk); #1 rstN = 1'b1;

    // R2: idle engine with a toggling acknowledge
    pat = 0;
    repeat (8) @(posedge clk);

    // R6/R8: tape to memory, six bytes, free-running bus
    cfg(2'd0, 16'h0012); cfg(2'd1, 16'h00BC); cfg(2'd2, 16'h004A);
    rdOp = 1'b1; pat = 1;
    x0 = xferCount; t0 = tcCount;
    cfg(2'd3, 16'd5);
    waitTc(200);
    repeat (4) @(negedge clk);
    chk("R8 transfers for count 5", 32'(xferCount - x0), 6);
    chk("R8 one terminal pulse", 32'(tcCount - t0), 1);
    chk("R5 end address after 6 bytes", 32'(memAddr), 32'h4ABC15);
    chk("R8 request dropped after tc", 32'(dmaReq), 0);

    // R7/R10: memory to tape with stalls, odd length, carry into high field
    rdOp = 1'b0; pat = 2;
    repeat (4) @(posedge clk);
    cfg(2'd0, 16'h00FF); cfg(2'd1, 16'h00FF); cfg(2'd2, 16'h0000);
    wrOp = 1'b1;
    x0 = xferCount;
    cfg(2'd3, 16'd8);
    waitTc(2000);
    repeat (12) @(negedge clk);
    chk("R8 transfers for count 8", 32'(xferCount - x0), 9);
    chk("R4 carry across field boundary", 32'(memAddr), 32'h010003);
    chk("R5 lane after odd byte count", 32'(memBhe), 1);

    // R9: both mode bits set, armed and granted, nothing moves
    wrOp = 1'b0;
    repeat (6) @(posedge clk);
    cfg(2'd0, 16'h00FF); cfg(2'd1, 16'h00FF); cfg(2'd2, 16'h007F);
    rdOp = 1'b1; wrOp = 1'b1; pat = 1;
    x0 = xferCount;
    cfg(2'd3, 16'd2);
    repeat (12) @(negedge clk);
    chk("R9 no transfer with both modes", 32'(xferCount - x0), 0);
    chk("R9 ack passes with both modes", 32'(ackOut), 32'(ackIn));

    // R4: wrap of the 23-bit counter
    wrOp = 1'b0;
    waitTc(200);
    repeat (4) @(negedge clk);
    chk("R8 transfers for count 2", 32'(xferCount - x0), 3);
    chk("R4 address wraps to zero", 32'(memAddr), 0);

    // R8: full 512-byte block under irregular grant and stalls
    pat = 2;
    x0 = xferCount; t0 = tcCount;
    cfg(2'd3, 16'd511);
    waitTc(20000);
    repeat (6) @(negedge clk);
    chk("R8 transfers for 512-byte block", 32'(xferCount - x0), 512);
    chk("R8 single pulse for block", 32'(tcCount - t0), 1);

    rdOp = 1'b0;
    repeat (5) @(posedge clk);
    finishRun();
  end
endmodule